// File: doc/BRIEF.md
# Integer Condition-Code and Loop-Branch Execute Unit

This block is the integer execute stage of a 32-bit core for four groups of operations: signed and unsigned subtraction, the logical family (and, and-not, or, xor, each with a form that places a 16-bit immediate in the upper half of the word), a loop branch that adds its operands and branches on the loop condition code, and a helper that forms a full 64-bit product of two 32-bit operands for a register pair. For each accepted operation it returns a result word, the new condition code (CC), the new loop condition code (LCC), a branch-taken decision, and the product split into its low (even register) and high (odd register) words.

The operands arrive as values together with their source register numbers. Register zero always reads as zero, whatever value is presented for it. A common use is xor of a register with register zero: the result is the register itself, and CC shows whether that register is zero. The loop branch supports countdown loops: a negative step keeps LCC set while the running count stays non-negative, so the loop ends once the count passes below zero.

The stage registers its outputs, so an operation presented on one clock edge appears on the outputs one cycle later. Address generation and register write-back are handled elsewhere.

Top module: `ialu_cc_exec`

## Requirements
- R1: Opcode 0 (signed subtract) and opcode 1 (unsigned subtract) produce result = src1 - src2 modulo 2^32. CC is set when src1 < src2, compared as signed numbers for opcode 0 and as unsigned numbers for opcode 1.
- R2: Opcodes 2 to 9 are the logical operations: 2 and, 3 and-high, 4 and-not (~src1 & src2), 5 and-not-high, 6 or, 7 or-high, 8 xor, 9 xor-high. A high form uses {src1[15:0], 16'h0000} as its first operand. CC is set exactly when the result is zero.
- R3: Opcode 10 (loop branch) produces result = src1 + src2 modulo 2^32, whether or not the branch is taken. branch_taken equals the LCC value presented with the operation.
- R4: For opcode 10, when src1 is negative (bit 31 set) the new LCC is 1 if the sum, read as a signed number, is >= 0. When src1 is non-negative the new LCC is 1 if the signed sum is < 0.
- R5: Opcode 11 (multiply helper) forms the unsigned 64-bit product of src1 and src2. prod_even carries bits 31:0, prod_odd carries bits 63:32, and result equals prod_even.
- R6: An operand whose register number is 0 is treated as the value zero, whatever value is presented on its value input.
- R7: out_valid rises exactly one cycle after an accepted in_valid and is low otherwise. While rst_n is low, at the next clock edge all outputs clear to zero.
- R8: Operations other than opcode 10 leave LCC equal to lcc_in and drive branch_taken low. Operations outside opcodes 0 to 9 leave CC equal to cc_in. Opcodes 12 to 15 have no effect: result and product are zero, and both flags pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Opcode, encoded as in R1 to R8 |
| src1_idx | input | 5 | Register number of the first operand |
| src1 | input | 32 | Value of the first operand |
| src2_idx | input | 5 | Register number of the second operand |
| src2 | input | 32 | Value of the second operand |
| cc_in | input | 1 | Current condition code |
| lcc_in | input | 1 | Current loop condition code |
| out_valid | output | 1 | Outputs hold a finished operation |
| result | output | 32 | Result word |
| cc_out | output | 1 | New condition code |
| lcc_out | output | 1 | New loop condition code |
| branch_taken | output | 1 | Loop branch decided taken |
| prod_even | output | 32 | Low word of the product (even register) |
| prod_odd | output | 32 | High word of the product (odd register) |

## Verification
The hardest case to reach from the ports is the LCC boundary of the loop branch. It needs a sum of exactly zero or exactly -1 while src1 has a chosen sign, with the sign of the sum wrapping at the 32-bit edges. Random operands almost never produce this. The stimulus therefore draws many operands from a pool of edge values (0, 1, -1, the extreme signed values and their neighbours). It also runs directed countdown steps in which the count reaches zero and then crosses it. Random register numbers are biased toward register zero, so that forcing an operand to zero is mixed into every operation.

// File: rtl/ialu_pkg.sv
// Package ialu_pkg
// Shared opcode encoding for the integer condition-code execute unit.
// Assumes a 4-bit opcode field. Unused codes (12..15) are treated as no-ops.
package ialu_pkg;

    typedef enum logic [3:0] {
        OP_SUBS    = 4'd0,
        OP_SUBU    = 4'd1,
        OP_AND     = 4'd2,
        OP_ANDH    = 4'd3,
        OP_ANDNOT  = 4'd4,
        OP_ANDNOTH = 4'd5,
        OP_OR      = 4'd6,
        OP_ORH     = 4'd7,
        OP_XOR     = 4'd8,
        OP_XORH    = 4'd9,
        OP_LOOPBR  = 4'd10,
        OP_MULW    = 4'd11
    } ialu_op_e;

    localparam int OP_W = 4;

    // Returns 1 for any of the eight logical opcodes.
    function automatic logic is_logic_op(input logic [OP_W-1:0] code);
        return (code >= OP_AND) && (code <= OP_XORH);
    endfunction

    // Returns 1 for the two subtract opcodes.
    function automatic logic is_sub_op(input logic [OP_W-1:0] code);
        return (code == OP_SUBS) || (code == OP_SUBU);
    endfunction

endpackage

// File: rtl/ialu_operand_sel.sv
// Module ialu_operand_sel
// Delivers one effective operand: the presented value, or zero when the
// register number is zero. Assumes register zero is hard-wired to zero.
module ialu_operand_sel #(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] reg_num,
    input  logic [DATA_W-1:0] reg_val,
    output logic [DATA_W-1:0] eff_val
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    // Force the operand to zero for the hard-wired zero register.
    always_comb begin
        if (reg_num == ZERO_REG) begin
            eff_val = '0;
        end else begin
            eff_val = reg_val;
        end
    end

endmodule

// File: rtl/ialu_sub_unit.sv
// Module ialu_sub_unit
// Computes a - b and the "a below b" flag, using a signed or an unsigned
// comparison as selected. Assumes two's complement operands.
module ialu_sub_unit #(
    parameter int DATA_W = 32
) (
    input  logic              use_signed,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] diff,
    output logic              below
);

    logic [DATA_W:0] wide_diff;
    logic            borrow;
    logic            sign_lt;

    // Form the difference with one extra bit to capture the borrow.
    always_comb begin
        wide_diff = {1'b0, opa} - {1'b0, opb};
        diff      = wide_diff[DATA_W-1:0];
        borrow    = wide_diff[DATA_W];
    end

    // Signed less-than from the operand signs and the difference sign.
    always_comb begin
        if (opa[DATA_W-1] != opb[DATA_W-1]) begin
            sign_lt = opa[DATA_W-1];
        end else begin
            sign_lt = wide_diff[DATA_W-1];
        end
    end

    // Pick the comparison that matches the opcode's signedness.
    always_comb begin
        below = use_signed ? sign_lt : borrow;
    end

endmodule

// File: rtl/ialu_logic_unit.sv
// Module ialu_logic_unit
// Evaluates the eight logical forms and a result-is-zero flag. A high form
// moves the low half of the first operand into the upper half of the word.
// Assumes DATA_W is even.
module ialu_logic_unit
    import ialu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OP_W-1:0]   code,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res,
    output logic              res_zero
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] opa_hi;
    logic [DATA_W-1:0] first;

    // Build the shifted-immediate operand used by the high forms.
    always_comb begin
        opa_hi = {opa[HALF_W-1:0], {HALF_W{1'b0}}};
    end

    // Opcode bit 0 selects the high form within each logical pair.
    always_comb begin
        first = code[0] ? opa_hi : opa;
    end

    // Evaluate the logical function named by the opcode.
    always_comb begin
        unique case (code)
            OP_AND, OP_ANDH:       res = first & opb;
            OP_ANDNOT, OP_ANDNOTH: res = ~first & opb;
            OP_OR, OP_ORH:         res = first | opb;
            OP_XOR, OP_XORH:       res = first ^ opb;
            default:               res = '0;
        endcase
    end

    // Zero detect that feeds the condition code.
    always_comb begin
        res_zero = (res == '0);
    end

endmodule

// File: rtl/ialu_loop_unit.sv
// Module ialu_loop_unit
// Loop branch: adds the step to the count and derives the next loop
// condition from the step's sign and the sum's sign. The taken decision
// uses the loop condition that was in force before this operation.
module ialu_loop_unit #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] step,
    input  logic [DATA_W-1:0] count,
    input  logic              lcc_prev,
    output logic [DATA_W-1:0] sum,
    output logic              lcc_next,
    output logic              taken
);

    logic step_neg;
    logic sum_neg;

    // Add with natural wrap-around at the word width.
    always_comb begin
        sum      = step + count;
        step_neg = step[DATA_W-1];
        sum_neg  = sum[DATA_W-1];
    end

    // Negative step: continue while the sum is non-negative; otherwise
    // continue while the sum is negative.
    always_comb begin
        if (step_neg) begin
            lcc_next = ~sum_neg;
        end else begin
            lcc_next = sum_neg;
        end
    end

    // Branch on the loop condition presented with the operation.
    always_comb begin
        taken = lcc_prev;
    end

endmodule

// File: rtl/ialu_mul_unit.sv
// Module ialu_mul_unit
// Unsigned DATA_W x DATA_W -> 2*DATA_W product, split into a low word for
// the even register and a high word for the odd register. USE_ARRAY picks
// an explicit shift-and-add array instead of the inferred multiplier.
module ialu_mul_unit #(
    parameter int DATA_W    = 32,
    parameter bit USE_ARRAY = 1'b0
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] prod_lo,
    output logic [DATA_W-1:0] prod_hi
);

    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] product;

    generate
        if (USE_ARRAY) begin : g_array
            // Accumulate one shifted partial product per multiplier bit.
            always_comb begin
                product = '0;
                for (int row = 0; row < DATA_W; row++) begin
                    if (opb[row]) begin
                        product = product + ({{DATA_W{1'b0}}, opa} << row);
                    end
                end
            end
        end else begin : g_infer
            // Inferred full-width multiply.
            always_comb begin
                product = {{DATA_W{1'b0}}, opa} * {{DATA_W{1'b0}}, opb};
            end
        end
    endgenerate

    // Split the product across the register pair.
    always_comb begin
        prod_lo = product[DATA_W-1:0];
        prod_hi = product[PROD_W-1:DATA_W];
    end

endmodule

// File: rtl/ialu_cc_exec.sv
// Module ialu_cc_exec
// Top of the integer condition-code execute stage. It selects the operands
// (register zero reads as zero), runs the subtract, logical, loop-branch and
// multiply units in parallel, merges the result and flags by opcode, and
// registers everything for one cycle of latency. Assumes one operation per
// cycle at most and a synchronous active-low reset.
module ialu_cc_exec
    import ialu_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AW    = 5,
    parameter bit MUL_ARRAY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [REG_AW-1:0] src1_idx,
    input  logic [DATA_W-1:0] src1,
    input  logic [REG_AW-1:0] src2_idx,
    input  logic [DATA_W-1:0] src2,
    input  logic              cc_in,
    input  logic              lcc_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              cc_out,
    output logic              lcc_out,
    output logic              branch_taken,
    output logic [DATA_W-1:0] prod_even,
    output logic [DATA_W-1:0] prod_odd
);

    localparam int NUM_SRC = 2;

    logic [REG_AW-1:0] idx_arr [NUM_SRC];
    logic [DATA_W-1:0] val_arr [NUM_SRC];
    logic [DATA_W-1:0] eff_arr [NUM_SRC];
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;

    // Gather the two source ports into arrays for the selector generate.
    always_comb begin
        idx_arr[0] = src1_idx;
        idx_arr[1] = src2_idx;
        val_arr[0] = src1;
        val_arr[1] = src2;
    end

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            ialu_operand_sel #(
                .DATA_W(DATA_W),
                .REG_AW(REG_AW)
            ) sel_i (
                .reg_num(idx_arr[s]),
                .reg_val(val_arr[s]),
                .eff_val(eff_arr[s])
            );
        end
    endgenerate

    // Name the effective operands.
    always_comb begin
        opa = eff_arr[0];
        opb = eff_arr[1];
    end

    logic [DATA_W-1:0] sub_diff;
    logic              sub_below;
    logic [DATA_W-1:0] log_res;
    logic              log_zero;
    logic [DATA_W-1:0] loop_sum;
    logic              loop_lcc;
    logic              loop_taken;
    logic [DATA_W-1:0] mul_lo;
    logic [DATA_W-1:0] mul_hi;

    ialu_sub_unit #(.DATA_W(DATA_W)) sub_i (
        .use_signed(op == OP_SUBS),
        .opa       (opa),
        .opb       (opb),
        .diff      (sub_diff),
        .below     (sub_below)
    );

    ialu_logic_unit #(.DATA_W(DATA_W)) logic_i (
        .code    (op),
        .opa     (opa),
        .opb     (opb),
        .res     (log_res),
        .res_zero(log_zero)
    );

    ialu_loop_unit #(.DATA_W(DATA_W)) loop_i (
        .step    (opa),
        .count   (opb),
        .lcc_prev(lcc_in),
        .sum     (loop_sum),
        .lcc_next(loop_lcc),
        .taken   (loop_taken)
    );

    ialu_mul_unit #(
        .DATA_W   (DATA_W),
        .USE_ARRAY(MUL_ARRAY)
    ) mul_i (
        .opa    (opa),
        .opb    (opb),
        .prod_lo(mul_lo),
        .prod_hi(mul_hi)
    );

    logic [DATA_W-1:0] nxt_result;
    logic [DATA_W-1:0] nxt_even;
    logic [DATA_W-1:0] nxt_odd;
    logic              nxt_cc;
    logic              nxt_lcc;
    logic              nxt_taken;

    // Merge unit outputs by opcode. Flags pass through unless the opcode owns them.
    always_comb begin
        nxt_result = '0;
        nxt_even   = '0;
        nxt_odd    = '0;
        nxt_cc     = cc_in;
        nxt_lcc    = lcc_in;
        nxt_taken  = 1'b0;
        if (is_sub_op(op)) begin
            nxt_result = sub_diff;
            nxt_cc     = sub_below;
        end else if (is_logic_op(op)) begin
            nxt_result = log_res;
            nxt_cc     = log_zero;
        end else if (op == OP_LOOPBR) begin
            nxt_result = loop_sum;
            nxt_lcc    = loop_lcc;
            nxt_taken  = loop_taken;
        end else if (op == OP_MULW) begin
            nxt_result = mul_lo;
            nxt_even   = mul_lo;
            nxt_odd    = mul_hi;
        end
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            cc_out       <= 1'b0;
            lcc_out      <= 1'b0;
            branch_taken <= 1'b0;
            prod_even    <= '0;
            prod_odd     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result       <= nxt_result;
                cc_out       <= nxt_cc;
                lcc_out      <= nxt_lcc;
                branch_taken <= nxt_taken;
                prod_even    <= nxt_even;
                prod_odd     <= nxt_odd;
            end
        end
    end

endmodule

// File: rtl/ialu_cc_exec_chk.sv
// Module ialu_cc_exec_chk
// Property checker for ialu_cc_exec, attached with bind. It relates each
// registered output to the port values of the cycle before.
module ialu_cc_exec_chk
    import ialu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   op,
    input logic [REG_AW-1:0] src1_idx,
    input logic [DATA_W-1:0] src1,
    input logic [REG_AW-1:0] src2_idx,
    input logic [DATA_W-1:0] src2,
    input logic              cc_in,
    input logic              lcc_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              cc_out,
    input logic              lcc_out,
    input logic              branch_taken,
    input logic [DATA_W-1:0] prod_even,
    input logic [DATA_W-1:0] prod_odd
);

    logic [DATA_W-1:0] a_eff;
    logic [DATA_W-1:0] b_eff;

    // Operand values as seen through the zero register.
    always_comb begin
        a_eff = (src1_idx == '0) ? '0 : src1;
        b_eff = (src2_idx == '0) ? '0 : src2;
    end

    // R7: out_valid follows in_valid by one cycle.
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R1: subtract order is first minus second.
    assert_sub_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(op) == OP_SUBS || $past(op) == OP_SUBU))
        |-> (result == $past(a_eff) - $past(b_eff)));

    // R2: each logical op sets CC when the result is zero.
    assert_logic_cc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) >= OP_AND && $past(op) <= OP_XORH)
        |-> (cc_out == (result == '0)));

    // R3: the loop branch follows the LCC presented with it.
    assert_loop_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == OP_LOOPBR) |-> (branch_taken == $past(lcc_in)));

    // R4: the new LCC depends on the step sign and the sum sign.
    assert_loop_lcc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == OP_LOOPBR)
        |-> (lcc_out == ($past(a_eff[DATA_W-1]) ? ~result[DATA_W-1] : result[DATA_W-1])));

    // R5: the result word of the multiply helper equals the even register word.
    assert_mul_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == OP_MULW) |-> (result == prod_even));

    // R6: xor of the zero register with itself yields zero and sets CC.
    assert_zero_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == OP_XOR && $past(src1_idx) == '0 && $past(src2_idx) == '0)
        |-> (result == '0 && cc_out));

    // R8: only the loop branch touches LCC or the branch decision.
    assert_pass_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) != OP_LOOPBR)
        |-> (!branch_taken && lcc_out == $past(lcc_in)));

endmodule

bind ialu_cc_exec ialu_cc_exec_chk #(
    .DATA_W(DATA_W),
    .REG_AW(REG_AW)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op          (op),
    .src1_idx    (src1_idx),
    .src1        (src1),
    .src2_idx    (src2_idx),
    .src2        (src2),
    .cc_in       (cc_in),
    .lcc_in      (lcc_in),
    .out_valid   (out_valid),
    .result      (result),
    .cc_out      (cc_out),
    .lcc_out     (lcc_out),
    .branch_taken(branch_taken),
    .prod_even   (prod_even),
    .prod_odd    (prod_odd)
);

// File: tb/ialu_cc_exec_tb_top.sv
// Scoreboard bench: the driver pushes model results into a queue, and the
// monitor pops and compares them as the design produces outputs.
module ialu_cc_exec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [4:0]  src1_idx = '0;
    logic [31:0] src1 = '0;
    logic [4:0]  src2_idx = '0;
    logic [31:0] src2 = '0;
    logic        cc_in = 1'b0;
    logic        lcc_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        cc_out;
    logic        lcc_out;
    logic        branch_taken;
    logic [31:0] prod_even;
    logic [31:0] prod_odd;

    always #4 clk = ~clk;

    ialu_cc_exec dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src1_idx(src1_idx), .src1(src1), .src2_idx(src2_idx), .src2(src2),
        .cc_in(cc_in), .lcc_in(lcc_in), .out_valid(out_valid),
        .result(result), .cc_out(cc_out), .lcc_out(lcc_out),
        .branch_taken(branch_taken), .prod_even(prod_even), .prod_odd(prod_odd)
    );

    typedef struct {
        logic [31:0] res;
        logic [31:0] lo;
        logic [31:0] hi;
        logic        cc;
        logic        lcc;
        logic        br;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // Behavioural model written from the requirements.
    function automatic exp_t model(input logic [3:0] o, input logic [4:0] i1, input logic [31:0] v1,
                                   input logic [4:0] i2, input logic [31:0] v2,
                                   input logic c, input logic l);
        exp_t e;
        logic [31:0] a, b, ah;
        logic [63:0] p;
        a = (i1 == 0) ? 32'd0 : v1;   // R6
        b = (i2 == 0) ? 32'd0 : v2;
        ah = {a[15:0], 16'h0};
        e.res = 0; e.lo = 0; e.hi = 0; e.cc = c; e.lcc = l; e.br = 0; e.req = "R8";
        case (o)
            4'd0: begin e.res = a - b; e.cc = ($signed(a) < $signed(b)); e.req = "R1"; end
            4'd1: begin e.res = a - b; e.cc = (a < b); e.req = "R1"; end
            4'd2: e.res = a & b;
            4'd3: e.res = ah & b;
            4'd4: e.res = ~a & b;
            4'd5: e.res = ~ah & b;
            4'd6: e.res = a | b;
            4'd7: e.res = ah | b;
            4'd8: e.res = a ^ b;
            4'd9: e.res = ah ^ b;
            4'd10: begin
                e.res = a + b; e.br = l;
                e.lcc = a[31] ? ($signed(e.res) >= 0) : ($signed(e.res) < 0);
                e.req = "R3/R4";
            end
            4'd11: begin
                p = {32'd0, a} * {32'd0, b};
                e.lo = p[31:0]; e.hi = p[63:32]; e.res = p[31:0]; e.req = "R5";
            end
            default: ;
        endcase
        if (o >= 4'd2 && o <= 4'd9) begin
            e.cc = (e.res == 0);
            e.req = "R2";
        end
        if ((i1 == 0 || i2 == 0) && o <= 4'd11) e.req = {e.req, "+R6"};
        return e;
    endfunction

    // Driver: present one operation at the falling edge and queue its expectation.
    task automatic apply(input logic [3:0] o, input logic [4:0] i1, input logic [31:0] v1,
                         input logic [4:0] i2, input logic [31:0] v2,
                         input logic c, input logic l);
        @(negedge clk);
        in_valid = 1'b1; op = o; src1_idx = i1; src1 = v1;
        src2_idx = i2; src2 = v2; cc_in = c; lcc_in = l;
        exp_q.push_back(model(o, i1, v1, i2, v2, c, l));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        op = $urandom_range(0, 15);
    endtask

    // Monitor: check outputs shortly after each rising edge (R7 timing).
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && !done) begin
                if (out_valid) begin
                    n_checks++;
                    if (exp_q.size() == 0) begin
                        n_fail++;
                        $display("FAIL R7: out_valid=1 expected 0");
                    end else begin
                        e = exp_q.pop_front();
                        if (result !== e.res || prod_even !== e.lo || prod_odd !== e.hi ||
                            cc_out !== e.cc || lcc_out !== e.lcc || branch_taken !== e.br) begin
                            n_fail++;
                            $display("FAIL %s: got res=%h lo=%h hi=%h cc=%b lcc=%b br=%b exp res=%h lo=%h hi=%h cc=%b lcc=%b br=%b",
                                     e.req, result, prod_even, prod_odd, cc_out, lcc_out, branch_taken,
                                     e.res, e.lo, e.hi, e.cc, e.lcc, e.br);
                        end
                    end
                end else if (exp_q.size() != 0) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL R7: out_valid=0 expected 1");
                end
            end
        end
    end

    function automatic logic [31:0] edge_val();
        case ($urandom_range(0, 9))
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            5: return 32'h8000_0001;
            6: return 32'hFFFF_FFFE;
            7: return 32'h0000_FFFF;
            default: return $urandom;
        endcase
    endfunction

    function automatic logic [4:0] pick_idx();
        return ($urandom_range(0, 5) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
    endfunction

    // Stimulus
    initial begin
        logic [31:0] cnt;
        repeat (3) @(negedge clk);
        // R7: reset state at the ports
        n_checks++;
        if (out_valid !== 1'b0 || result !== 32'd0 || cc_out !== 1'b0 || lcc_out !== 1'b0 ||
            branch_taken !== 1'b0 || prod_even !== 32'd0 || prod_odd !== 32'd0) begin
            n_fail++;
            $display("FAIL R7: reset outputs valid=%b res=%h exp valid=0 res=0", out_valid, result);
        end
        rst_n = 1'b1;
        // R1 directed: operand order and signed/unsigned compare
        apply(4'd0, 5'd3, 32'd3, 5'd4, 32'd5, 1'b0, 1'b0);
        apply(4'd1, 5'd3, 32'd5, 5'd4, 32'd3, 1'b1, 1'b0);
        apply(4'd0, 5'd3, 32'hFFFF_FFFF, 5'd4, 32'd1, 1'b0, 1'b1);
        apply(4'd1, 5'd3, 32'hFFFF_FFFF, 5'd4, 32'd1, 1'b1, 1'b1);
        apply(4'd0, 5'd3, 32'd7, 5'd4, 32'd7, 1'b1, 1'b0);
        // R2 directed: high forms and zero results
        apply(4'd3, 5'd5, 32'h1234_00FF, 5'd6, 32'hFFFF_FFFF, 1'b0, 1'b0);
        apply(4'd5, 5'd5, 32'h0000_FFFF, 5'd6, 32'hFFFF_0000, 1'b0, 1'b0);
        apply(4'd7, 5'd5, 32'h0000_0000, 5'd6, 32'h0000_0000, 1'b0, 1'b0);
        // R6: xor with register zero as a zero test; nonzero value on r0 ignored
        apply(4'd8, 5'd0, 32'hDEAD_BEEF, 5'd9, 32'd0, 1'b0, 1'b0);
        apply(4'd8, 5'd0, 32'hDEAD_BEEF, 5'd9, 32'd42, 1'b1, 1'b0);
        apply(4'd0, 5'd7, 32'd10, 5'd0, 32'd99, 1'b1, 1'b0);
        // R3/R4: countdown loop with step -1 crossing zero
        cnt = 32'd3;
        for (int k = 0; k < 5; k++) begin
            apply(4'd10, 5'd2, 32'hFFFF_FFFF, 5'd3, cnt, (k % 2) == 0, k != 4);
            cnt = cnt - 32'd1;
        end
        apply(4'd10, 5'd2, 32'd1, 5'd3, 32'hFFFF_FFFE, 1'b0, 1'b1);
        apply(4'd10, 5'd2, 32'd1, 5'd3, 32'h7FFF_FFFF, 1'b0, 1'b0);
        apply(4'd10, 5'd2, 32'h8000_0000, 5'd3, 32'h8000_0000, 1'b0, 1'b1);
        // R5: multiply extremes
        apply(4'd11, 5'd1, 32'hFFFF_FFFF, 5'd2, 32'hFFFF_FFFF, 1'b1, 1'b1);
        apply(4'd11, 5'd1, 32'h0001_0000, 5'd2, 32'h0001_0000, 1'b0, 1'b0);
        // R8: unused opcodes
        apply(4'd12, 5'd1, 32'h5555_5555, 5'd2, 32'd3, 1'b1, 1'b0);
        apply(4'd15, 5'd1, 32'h5555_5555, 5'd2, 32'd3, 1'b0, 1'b1);
        idle();
        idle();
        // Random mix with edge operands and bubbles
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 7) == 0) begin
                idle();
            end else begin
                apply(4'($urandom_range(0, 15)), pick_idx(), edge_val(),
                      pick_idx(), edge_val(), 1'($urandom), 1'($urandom));
            end
        end
        idle();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule